// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits between a processor core and the clock domains around it and decides, cycle by cycle, which domains receive a clock enable. It has seven enable outputs: CPU, memory, synchronous peripherals (timers, serial ports, SPI, 2-wire), interrupt logic, ADC, asynchronous timer and main oscillator. While the core runs, every enable is high. When software selects a low-power mode, sets the sleep enable bit and issues a one-cycle sleep request, the block latches the mode. It then drops the enables of every domain that mode does not keep alive.

The block leaves sleep when a wake input that the latched mode accepts goes high. Modes that stopped the main oscillator need time for it to start. After waking from one of them, the block turns every domain back on except the CPU. It holds the CPU off for a start-up count of cycles taken from an input. The latched mode stays visible on an output after wake-up, until the next sleep entry.

All pins are plain control and status levels. There is no data stream and so no valid/ready handshake. The sleep request is a level that is sampled on each rising edge while the block is running.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: Synchronous reset (`rst_i` high at an edge) results in: all seven enables 1, `asleep_o` 0 and `last_mode_o` 3'b111.
- R2: Sleep is entered at the edge where `sleep_req_i`=1, `sleep_en_i`=1 and `mode_i` is legal, with the block running. From the next cycle `asleep_o`=1 and `en_cpu_o`=0. In Idle (`mode_i`=3'b000) every other enable stays 1.
- R3: In ADC noise reduction mode (3'b001), only `en_adc_o`, `en_async_o` and `en_osc_o` are 1.
- R4: In power-down mode (3'b010), all enables are 0. In power-save mode (3'b011), only `en_async_o` is 1.
- R5: In standby mode (3'b110), only `en_osc_o` is 1.
- R6: A sleep request is ignored in either of these cases: `sleep_en_i`=0, or `mode_i` is 3'b100, 3'b101 or 3'b111. All enables stay 1 and `last_mode_o` is unchanged.
- R7: The mode is latched at entry and shown on `last_mode_o`. While asleep, changes on `mode_i` and further sleep requests have no effect.
- R8: Wake inputs are qualified by the latched mode:
  - `wake_ext_i` wakes every mode.
  - `wake_atmr_i` wakes power-save and Idle.
  - `wake_adc_i` wakes ADC noise reduction and Idle.
  - `wake_other_i` wakes Idle only.
  - An unqualified wake leaves the sleep enables unchanged.
- R9: Waking from power-down or power-save with `startup_cnt_i`=N>0 gives N cycles with every enable 1 except `en_cpu_o`=0. After those cycles, all enables are 1.
- R10: Waking from Idle, ADC noise reduction or standby, or from power-down or power-save with N=0, sets all enables to 1 in the cycle after the wake edge.
- R11: `last_mode_o` keeps the last entered mode after wake-up, until the next accepted request.
- R12: Reset from sleep or from start-up returns all enables to 1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Requested low-power mode |
| sleep_en_i | input | 1 | Sleep enable bit |
| sleep_req_i | input | 1 | Sleep request from the CPU |
| startup_cnt_i | input | CNT_W | Oscillator start-up cycles |
| wake_ext_i | input | 1 | External/pin-change interrupt |
| wake_atmr_i | input | 1 | Asynchronous timer interrupt |
| wake_adc_i | input | 1 | ADC conversion complete interrupt |
| wake_other_i | input | 1 | Any other enabled interrupt |
| en_cpu_o | output | 1 | CPU clock enable |
| en_mem_o | output | 1 | Memory clock enable |
| en_sync_o | output | 1 | Synchronous peripheral clock enable |
| en_irq_o | output | 1 | Interrupt logic clock enable |
| en_adc_o | output | 1 | ADC clock enable |
| en_async_o | output | 1 | Asynchronous timer clock enable |
| en_osc_o | output | 1 | Main oscillator enable |
| asleep_o | output | 1 | Block is in a sleep mode |
| last_mode_o | output | 3 | Latched mode (3'b111 after reset) |

## Verification
Each internal fault shows at the ports within one cycle of the edge where it occurs:
- A wrong state register shows up as a wrong enable pattern or a wrong `asleep_o` in the cycle after the edge that should have moved it.
- A corrupted latched mode shows on `last_mode_o` and in the set of domains kept alive.
- A start-up counter that is off by one lengthens or shortens the run of CPU-off cycles by exactly one, and the check after each wake catches that cycle.
- A wrong wake mask either wakes the block early or leaves it asleep after a qualified wake. Either case differs from the expected pattern in the very next cycle.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WARM} slp_state_e;

  localparam int MODE_W = 3;
  localparam int NUM_WAKE = 4;

  localparam logic [MODE_W-1:0] MODE_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_ADCNR = 3'b001;
  localparam logic [MODE_W-1:0] MODE_PDOWN = 3'b010;
  localparam logic [MODE_W-1:0] MODE_PSAVE = 3'b011;
  localparam logic [MODE_W-1:0] MODE_STBY  = 3'b110;
  localparam logic [MODE_W-1:0] MODE_NONE  = 3'b111;

  // wake vector bit positions
  localparam int WK_EXT   = 0;
  localparam int WK_ATMR  = 1;
  localparam int WK_ADC   = 2;
  localparam int WK_OTHER = 3;

  typedef struct packed {
    logic osc;
    logic async_tmr;
    logic adc;
    logic irq;
    logic sync_per;
    logic mem;
    logic cpu;
  } dom_en_t;

  localparam int NUM_DOM = $bits(dom_en_t);

endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_ctl_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              legal_o,
  output logic              osc_stops_o,
  output dom_en_t           dom_o
);

  always_comb begin
    legal_o     = 1'b1;
    osc_stops_o = 1'b0;
    dom_o       = '1;
    unique case (mode_i)
      MODE_IDLE: begin
        dom_o.cpu = 1'b0;
      end
      MODE_ADCNR: begin
        dom_o          = '0;
        dom_o.adc       = 1'b1;
        dom_o.async_tmr = 1'b1;
        dom_o.osc       = 1'b1;
      end
      MODE_PDOWN: begin
        dom_o       = '0;
        osc_stops_o = 1'b1;
      end
      MODE_PSAVE: begin
        dom_o           = '0;
        dom_o.async_tmr = 1'b1;
        osc_stops_o     = 1'b1;
      end
      MODE_STBY: begin
        dom_o     = '0;
        dom_o.osc = 1'b1;
      end
      default: begin
        legal_o = 1'b0;
      end
    endcase
  end

  // R2: any legal sleep pattern gates the CPU
  always_comb begin
    if (legal_o) begin
      p_legal_gates_cpu_r2: assert (dom_o.cpu == 1'b0);
    end
  end

endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual
  import sleep_ctl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  output logic                wake_o
);

  logic [NUM_WAKE-1:0] mask;

  always_comb begin
    mask = '0;
    mask[WK_EXT] = 1'b1;
    unique case (mode_i)
      MODE_IDLE:  mask = '1;
      MODE_ADCNR: mask[WK_ADC] = 1'b1;
      MODE_PSAVE: mask[WK_ATMR] = 1'b1;
      default:    ;
    endcase
  end

  logic [NUM_WAKE-1:0] hit;
  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_hit
    assign hit[g] = wake_i[g] & mask[g];
  end

  assign wake_o = |hit;

  // R8: an external wake is always accepted
  p_ext_always_wakes_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_i[WK_EXT] |-> wake_o);

  // R8: power-down and standby accept nothing but the external source
  p_pd_only_ext_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    ((mode_i == MODE_PDOWN || mode_i == MODE_STBY) && wake_o) |-> wake_i[WK_EXT]);

endmodule

// File: rtl/sleep_warm_timer.sv
module sleep_warm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign last_o = (cnt_q == ONE);

  // R9: a running count steps down by one each cycle
  p_cnt_steps_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_ctl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [2:0]       mode_i,
  input  logic             sleep_en_i,
  input  logic             sleep_req_i,
  input  logic [CNT_W-1:0] startup_cnt_i,
  input  logic             wake_ext_i,
  input  logic             wake_atmr_i,
  input  logic             wake_adc_i,
  input  logic             wake_other_i,
  output logic             en_cpu_o,
  output logic             en_mem_o,
  output logic             en_sync_o,
  output logic             en_irq_o,
  output logic             en_adc_o,
  output logic             en_async_o,
  output logic             en_osc_o,
  output logic             asleep_o,
  output logic [2:0]       last_mode_o
);

  slp_state_e        st_q;
  logic [MODE_W-1:0] mode_q;

  logic    req_legal, req_osc_unused;
  dom_en_t req_dom_unused;
  logic    cur_legal_unused, cur_osc_stops;
  dom_en_t cur_dom;

  sleep_mode_decode u_req_dec (
    .mode_i      (mode_i),
    .legal_o     (req_legal),
    .osc_stops_o (req_osc_unused),
    .dom_o       (req_dom_unused)
  );

  sleep_mode_decode u_cur_dec (
    .mode_i      (mode_q),
    .legal_o     (cur_legal_unused),
    .osc_stops_o (cur_osc_stops),
    .dom_o       (cur_dom)
  );

  logic [NUM_WAKE-1:0] wake_vec;
  logic                wake;

  always_comb begin
    wake_vec            = '0;
    wake_vec[WK_EXT]    = wake_ext_i;
    wake_vec[WK_ATMR]   = wake_atmr_i;
    wake_vec[WK_ADC]    = wake_adc_i;
    wake_vec[WK_OTHER]  = wake_other_i;
  end

  sleep_wake_qual u_wake (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (mode_q),
    .wake_i (wake_vec),
    .wake_o (wake)
  );

  logic accept, warm_load, warm_last;

  assign accept    = (st_q == ST_RUN) && sleep_req_i && sleep_en_i && req_legal;
  assign warm_load = (st_q == ST_SLEEP) && wake && cur_osc_stops;

  sleep_warm_timer #(.CNT_W(CNT_W)) u_warm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (warm_load),
    .load_val_i (startup_cnt_i),
    .last_o     (warm_last)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= ST_RUN;
      mode_q <= MODE_NONE;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (accept) begin
            st_q   <= ST_SLEEP;
            mode_q <= mode_i;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            if (cur_osc_stops && startup_cnt_i != '0) st_q <= ST_WARM;
            else                                      st_q <= ST_RUN;
          end
        end
        ST_WARM: begin
          if (warm_last) st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  dom_en_t dom;
  always_comb begin
    dom = '1;
    unique case (st_q)
      ST_SLEEP: dom = cur_dom;
      ST_WARM:  dom.cpu = 1'b0;
      default:  dom = '1;
    endcase
  end

  assign en_cpu_o    = dom.cpu;
  assign en_mem_o    = dom.mem;
  assign en_sync_o   = dom.sync_per;
  assign en_irq_o    = dom.irq;
  assign en_adc_o    = dom.adc;
  assign en_async_o  = dom.async_tmr;
  assign en_osc_o    = dom.osc;
  assign asleep_o    = (st_q == ST_SLEEP);
  assign last_mode_o = mode_q;

  // R2: no CPU clock while asleep
  p_cpu_off_asleep_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    asleep_o |-> !en_cpu_o);

  // R6: a request that is disabled or illegal leaves the block running
  p_bad_req_ignored_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_RUN && sleep_req_i && !(sleep_en_i && req_legal)) |=>
      (st_q == ST_RUN && $stable(mode_q)));

  // R7: latched mode frozen during sleep
  p_mode_frozen_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_SLEEP && !wake) |=> (st_q == ST_SLEEP && $stable(mode_q)));

  // R9: start-up keeps the CPU off while the oscillator runs
  p_warm_cpu_off_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_WARM) |-> (!en_cpu_o && en_osc_o));

  // R10: fast wake when the oscillator never stopped
  p_fast_wake_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_SLEEP && wake && !cur_osc_stops) |=> (st_q == ST_RUN));

  // R12: reset always restores every enable
  p_reset_all_on_r12: assert property (@(posedge clk_i)
    $past(rst_i) |-> (dom == '1 && !asleep_o));

endmodule

// File: tb/sleep_clk_ctrl_tb.sv
module sleep_clk_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_i;
  logic [2:0]       mode_i;
  logic             sleep_en_i, sleep_req_i;
  logic [CNT_W-1:0] startup_cnt_i;
  logic             wake_ext_i, wake_atmr_i, wake_adc_i, wake_other_i;
  logic en_cpu_o, en_mem_o, en_sync_o, en_irq_o, en_adc_o, en_async_o, en_osc_o;
  logic             asleep_o;
  logic [2:0]       last_mode_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_clk_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_i(rst_i), .mode_i(mode_i), .sleep_en_i(sleep_en_i),
    .sleep_req_i(sleep_req_i), .startup_cnt_i(startup_cnt_i),
    .wake_ext_i(wake_ext_i), .wake_atmr_i(wake_atmr_i), .wake_adc_i(wake_adc_i),
    .wake_other_i(wake_other_i),
    .en_cpu_o(en_cpu_o), .en_mem_o(en_mem_o), .en_sync_o(en_sync_o),
    .en_irq_o(en_irq_o), .en_adc_o(en_adc_o), .en_async_o(en_async_o),
    .en_osc_o(en_osc_o), .asleep_o(asleep_o), .last_mode_o(last_mode_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] exp_last;

  localparam logic [6:0] ALL_ON  = 7'h7F;
  localparam logic [6:0] WARM_EN = 7'h7E;

  // order {osc,async,adc,irq,sync,mem,cpu}
  function automatic logic [6:0] sleep_pattern(input logic [2:0] m);
    case (m)
      3'b000:  return 7'b1111110;
      3'b001:  return 7'b1110000;
      3'b010:  return 7'b0000000;
      3'b011:  return 7'b0100000;
      3'b110:  return 7'b1000000;
      default: return ALL_ON;
    endcase
  endfunction

  function automatic logic is_legal(input logic [2:0] m);
    return (m == 3'b000 || m == 3'b001 || m == 3'b010 || m == 3'b011 || m == 3'b110);
  endfunction

  function automatic logic osc_stop(input logic [2:0] m);
    return (m == 3'b010 || m == 3'b011);
  endfunction

  // wake vector order {other,adc,atmr,ext}
  function automatic logic wakes(input logic [2:0] m, input logic [3:0] w);
    logic ok;
    ok = w[0];
    if (m == 3'b000) ok = |w;
    if (m == 3'b001) ok = ok | w[2];
    if (m == 3'b011) ok = ok | w[1];
    return ok;
  endfunction

  function automatic logic [6:0] en_vec();
    return {en_osc_o, en_async_o, en_adc_o, en_irq_o, en_sync_o, en_mem_o, en_cpu_o};
  endfunction

  task automatic check(input string tag, input logic [6:0] e_en,
                       input logic e_sl, input logic [2:0] e_md);
    n_chk++;
    if (en_vec() !== e_en || asleep_o !== e_sl || last_mode_o !== e_md) begin
      n_bad++;
      $display("FAIL %s: en=%b exp %b asleep=%b exp %b mode=%b exp %b",
               tag, en_vec(), e_en, asleep_o, e_sl, last_mode_o, e_md);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_wake(input logic [3:0] w);
    {wake_other_i, wake_adc_i, wake_atmr_i, wake_ext_i} = w;
  endtask

  // issue a request and check the result
  task automatic request(input logic [2:0] m, input logic en, output logic slept);
    mode_i = m; sleep_en_i = en; sleep_req_i = 1'b1;
    step();
    sleep_req_i = 1'b0;
    slept = en && is_legal(m);
    if (slept) begin
      exp_last = m;
      check("R2/R3/R4/R5 entry", sleep_pattern(m), 1'b1, exp_last);
    end else begin
      check("R6 ignored request", ALL_ON, 1'b0, exp_last);
    end
  endtask

  // apply one wake vector while asleep; returns whether woken
  task automatic wake_step(input logic [2:0] lm, input logic [3:0] w,
                           input int n, output logic woke);
    set_wake(w);
    step();
    set_wake(4'b0);
    woke = wakes(lm, w);
    if (!woke) begin
      check("R8/R7 no wake", sleep_pattern(lm), 1'b1, exp_last);
    end else if (osc_stop(lm) && n != 0) begin
      check("R9 warm first", WARM_EN, 1'b0, exp_last);
      for (int j = 1; j < n; j++) begin
        step();
        check("R9 warm hold", WARM_EN, 1'b0, exp_last);
      end
      step();
      check("R9 warm done R11", ALL_ON, 1'b0, exp_last);
    end else begin
      check("R10 fast wake R11", ALL_ON, 1'b0, exp_last);
    end
  endtask

  logic done_flag = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic sl, wk;
    void'($urandom(32'd4711));
    rst_i = 1'b1; mode_i = 3'b000; sleep_en_i = 1'b0; sleep_req_i = 1'b0;
    startup_cnt_i = '0; set_wake(4'b0);
    exp_last = 3'b111;
    step(); step();
    check("R1 reset state", ALL_ON, 1'b0, 3'b111);
    rst_i = 1'b0;
    step();
    check("R1 after release", ALL_ON, 1'b0, 3'b111);

    // directed: idle, wake by other source
    request(3'b000, 1'b1, sl);
    wake_step(3'b000, 4'b1000, 0, wk);

    // directed: power-down ignores timer/adc/other (R8), mode change ignored (R7)
    startup_cnt_i = 8'd3;
    request(3'b010, 1'b1, sl);
    mode_i = 3'b000; sleep_req_i = 1'b1; sleep_en_i = 1'b1;
    wake_step(3'b010, 4'b1110, 3, wk);
    sleep_req_i = 1'b0;
    wake_step(3'b010, 4'b0001, 3, wk);

    // directed: power-save wakes on async timer with zero start-up (R10)
    startup_cnt_i = 8'd0;
    request(3'b011, 1'b1, sl);
    wake_step(3'b011, 4'b0010, 0, wk);

    // directed: standby rejects adc, wakes on ext
    request(3'b110, 1'b1, sl);
    wake_step(3'b110, 4'b0100, 0, wk);
    wake_step(3'b110, 4'b0001, 0, wk);

    // directed: ADC noise reduction wakes on adc-complete
    request(3'b001, 1'b1, sl);
    wake_step(3'b001, 4'b0010, 0, wk);
    wake_step(3'b001, 4'b0100, 0, wk);

    // directed: illegal modes and disabled requests (R6)
    request(3'b100, 1'b1, sl);
    request(3'b101, 1'b1, sl);
    request(3'b111, 1'b1, sl);
    request(3'b010, 1'b0, sl);

    // directed: reset during sleep (R12)
    request(3'b010, 1'b1, sl);
    rst_i = 1'b1; step(); rst_i = 1'b0;
    exp_last = 3'b111;
    check("R12 reset from sleep", ALL_ON, 1'b0, exp_last);

    // directed: reset during start-up (R12)
    startup_cnt_i = 8'd6;
    request(3'b011, 1'b1, sl);
    set_wake(4'b0001); step(); set_wake(4'b0);
    check("R9 warm entered", WARM_EN, 1'b0, exp_last);
    rst_i = 1'b1; step(); rst_i = 1'b0;
    exp_last = 3'b111;
    check("R12 reset from warm", ALL_ON, 1'b0, exp_last);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      logic [2:0] m;
      logic       en;
      int         n;
      m  = 3'($urandom());
      en = ($urandom() % 8) != 0;
      n  = int'($urandom() % 6);
      startup_cnt_i = CNT_W'(n);
      request(m, en, sl);
      if (sl) begin
        for (int c = 0; c < 12; c++) begin
          logic [3:0] w;
          w = (($urandom() % 3) == 0) ? 4'($urandom()) : 4'b0;
          if (c == 11) w = 4'b0001;
          mode_i      = 3'($urandom());
          sleep_req_i = 1'($urandom());
          wake_step(m, w, n, wk);
          sleep_req_i = 1'b0;
          if (wk) break;
        end
      end
      // wake pins during run have no effect
      set_wake(4'($urandom()));
      step();
      set_wake(4'b0);
      check("R11 run idle", ALL_ON, 1'b0, exp_last);
    end

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule